// File: doc/BRIEF.md
# Zero-word removal codec

This block shrinks a stream of 32-bit data words in which all-zero words are frequent. On the encode side, every incoming word becomes a token: a lone 0 bit when the word is zero, or a 1 bit followed by the full word otherwise. The tokens are packed, most significant bit first, into 32-bit output words. A token may straddle two output words. A flush pulse pushes out the last partial word, with its unused low bits padded with zeros.

The decode side reverses the process. Software starts a decode with a start pulse that carries the number of words to rebuild. The decoder then pulls packed words, emits one zero word for each 0 token and one gathered word for each 1 token, and stops after the requested count. Any padding left at the end of the stream is dropped. Both sides use word-wide valid/ready handshakes. They are independent and can run at the same time.

Top module: `zero_word_codec`

## Requirements
- R1: After reset, `encValid` and `decOutValid` are low, `inReady` is high and `decInReady` is low.
- R2: A zero input word adds exactly one 0 bit to the packed stream (for example, zero, zero, 0xFFFFFFFF, then flush gives 0x3FFFFFFF, 0xE0000000).
- R3: A non-zero input word adds a 1 bit followed by its 32 bits, most significant bit first (for example, 0xA5A5A5A5 then flush gives 0xD2D2D2D2, 0x80000000).
- R4: Tokens are packed in input order, most significant bit first, into consecutive output words, and a token that does not fit spills into the next word.
- R5: A flush pulse emits any partial word with its low bits zero and holds `inReady` low until the encoder is empty. A flush on an empty encoder emits nothing.
- R6: While `encValid` is high and `encReady` is low, `encValid` stays high and no bit is lost or reordered.
- R7: The decoder outputs a zero word for each 0 token and, for each 1 token, the 32 bits that follow it.
- R8: After `decStart`, the decoder outputs exactly `decCount` words, consumes no input word beyond the one that holds the last token, ignores pad bits, and keeps `decInReady` and `decOutValid` low while idle.
- R9: A `decStart` pulse while a decode is still in progress has no effect.
- R10: While `decOutValid` is high and `decOutReady` is low, `decOutValid` stays high and `decOut` stays unchanged.
- R11: With `encReady` held high, a stream of zero words is accepted at one word per cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 32 | Word to encode |
| inValid | input | 1 | `inData` is valid |
| inReady | output | 1 | Encoder accepts `inData` |
| flush | input | 1 | Pulse: drain the encoder, padding the last word |
| encData | output | 32 | Packed output word |
| encValid | output | 1 | `encData` is valid |
| encReady | input | 1 | Consumer accepts `encData` |
| decIn | input | 32 | Packed word to decode |
| decInValid | input | 1 | `decIn` is valid |
| decInReady | output | 1 | Decoder accepts `decIn` |
| decStart | input | 1 | Pulse: begin a decode of `decCount` words |
| decCount | input | 16 | Number of words to rebuild |
| decOut | output | 32 | Rebuilt word |
| decOutValid | output | 1 | `decOut` is valid |
| decOutReady | input | 1 | Consumer accepts `decOut` |

## Verification
If the encoder's bit count goes wrong, every packed word after that point shifts. The first wrong bit therefore shows up within one or two output words of the error, and the comparison against a packing model built in the bench catches it at that word. A wrong decoder bit count or token read produces a wrong rebuilt word right away, or a decode that reads one input word too many or too few. The bench counts consumed input words and checks for idle behaviour after the requested count to catch both cases. Stalls on both output sides, with data held steady across them, expose any handshake that drops or repeats a token.

// File: rtl/zrc_pkg.sv
package zrc_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic encEmit;   // packed word leaves the encoder
    logic encTake;   // input word enters the encoder
    logic decFire;   // one token is consumed by the decoder
    logic decLoad;   // packed word enters the decoder
    logic decClear;  // decoder bit buffer is emptied
  } zrc_strobe_t;
endpackage

// File: rtl/zrc_dpath.sv
module zrc_dpath
  import zrc_pkg::*;
#(
  parameter int W = 32,
  parameter int FILL_W = $clog2(2 * W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  zrc_strobe_t       stb,
  input  logic [W-1:0]      inData,
  input  logic [W-1:0]      decIn,
  output logic [FILL_W-1:0] encFill,
  output logic [W-1:0]      encWord,
  output logic [FILL_W-1:0] decFill,
  output logic              decTokValid,
  output logic              decNeedHold,
  output logic              decNeedFire,
  output logic [W-1:0]      decWord
);
  localparam int BUF_W = 2 * W;
  localparam logic [FILL_W-1:0] F_WORD = FILL_W'(W);
  localparam logic [FILL_W-1:0] F_TOK  = FILL_W'(W + 1);
  localparam logic [FILL_W-1:0] F_ONE  = FILL_W'(1);
  localparam logic [FILL_W-1:0] F_BUF  = FILL_W'(BUF_W);

  // ---------------- encoder bit buffer (MSB aligned) ----------------
  logic [BUF_W-1:0]  encBuf, encShift, encNext, encTok;
  logic [FILL_W-1:0] encPost, encFillNext;
  logic              inZero;

  always_comb begin
    inZero      = (inData == '0);
    encTok      = {1'b1, inData, {(W-1){1'b0}}};
    encShift    = stb.encEmit ? (encBuf << W) : encBuf;
    encPost     = stb.encEmit ? ((encFill >= F_WORD) ? encFill - F_WORD : '0) : encFill;
    encNext     = encShift;
    encFillNext = encPost;
    if (stb.encTake) begin
      if (!inZero) encNext = encShift | (encTok >> encPost);
      encFillNext = encPost + (inZero ? F_ONE : F_TOK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encBuf  <= '0;
      encFill <= '0;
    end else begin
      encBuf  <= encNext;
      encFill <= encFillNext;
    end
  end

  assign encWord = encBuf[BUF_W-1 -: W];

  // R4
  enc_fill_chk: assert property (@(posedge clk) disable iff (!rstN) encFill <= F_BUF);

  // ---------------- decoder bit buffer (MSB aligned) ----------------
  logic [BUF_W-1:0]  decBuf, decPostBuf, decNext;
  logic [FILL_W-1:0] decLen, decPostFill, decFireFill, decFillNext;
  logic              decTop, decFireTop;

  always_comb begin
    decTop      = decBuf[BUF_W-1];
    decLen      = decTop ? F_TOK : F_ONE;
    decTokValid = (decFill != '0) && (!decTop || decFill >= F_TOK);
    decWord     = decTop ? decBuf[BUF_W-2 -: W] : '0;
    decNeedHold = !decTokValid;
    decFireFill = decFill - decLen;
    decFireTop  = decTop ? decBuf[BUF_W-2-W] : decBuf[BUF_W-2];
    decNeedFire = (decFireFill == '0) || (decFireTop && decFireFill < F_TOK);
    decPostBuf  = stb.decFire ? (decBuf << decLen) : decBuf;
    decPostFill = stb.decFire ? decFireFill : decFill;
    decNext     = decPostBuf;
    decFillNext = decPostFill;
    if (stb.decLoad) begin
      decNext     = decPostBuf | ({decIn, {W{1'b0}}} >> decPostFill);
      decFillNext = decPostFill + F_WORD;
    end
    if (stb.decClear) begin
      decNext     = '0;
      decFillNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decBuf  <= '0;
      decFill <= '0;
    end else begin
      decBuf  <= decNext;
      decFill <= decFillNext;
    end
  end

  // R7
  dec_fill_chk: assert property (@(posedge clk) disable iff (!rstN) decFill <= F_BUF);
endmodule

// File: rtl/zrc_ctrl.sv
module zrc_ctrl
  import zrc_pkg::*;
#(
  parameter int W = 32,
  parameter int CNT_W = 16,
  parameter int FILL_W = $clog2(2 * W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              encReady,
  input  logic              flush,
  input  logic [FILL_W-1:0] encFill,
  input  logic              decInValid,
  input  logic              decOutReady,
  input  logic              decStart,
  input  logic [CNT_W-1:0]  decCount,
  input  logic              decTokValid,
  input  logic              decNeedHold,
  input  logic              decNeedFire,
  output zrc_strobe_t       stb,
  output logic              inReady,
  output logic              encValid,
  output logic              decInReady,
  output logic              decOutValid
);
  localparam logic [FILL_W-1:0] F_WORD = FILL_W'(W);
  localparam logic [FILL_W-1:0] F_LAST = FILL_W'(W - 1);
  localparam logic [CNT_W-1:0]  C_ONE  = CNT_W'(1);

  logic              flushPend;
  logic [CNT_W-1:0]  remain;
  logic [FILL_W-1:0] encPost;
  logic              encEmit, decFire, lastFire, startOk;

  // ---------------- encoder flow ----------------
  always_comb begin
    encValid = (encFill >= F_WORD) || (flushPend && encFill != '0);
    encEmit  = encValid && encReady;
    encPost  = encEmit ? ((encFill >= F_WORD) ? encFill - F_WORD : '0) : encFill;
    inReady  = !flushPend && (encPost <= F_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         flushPend <= 1'b0;
    else if (flush)                    flushPend <= 1'b1;
    else if (flushPend && encPost == '0) flushPend <= 1'b0;
  end

  // ---------------- decoder flow ----------------
  always_comb begin
    startOk     = decStart && (remain == '0);
    decOutValid = (remain != '0) && decTokValid;
    decFire     = decOutValid && decOutReady;
    lastFire    = decFire && (remain == C_ONE);
    decInReady  = (remain != '0) && !lastFire && (decFire ? decNeedFire : decNeedHold);
  end

  always_ff @(posedge clk) begin
    if (!rstN)        remain <= '0;
    else if (startOk) remain <= decCount;
    else if (decFire) remain <= remain - C_ONE;
  end

  always_comb begin
    stb.encEmit  = encEmit;
    stb.encTake  = inValid && inReady;
    stb.decFire  = decFire;
    stb.decLoad  = decInValid && decInReady;
    stb.decClear = startOk || lastFire;
  end

  // R6
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValid && !encReady |=> encValid);
  // R5
  flush_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !inReady);
  // R10
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid && !decOutReady |=> decOutValid);
  // R8
  dec_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastFire |=> !decOutValid && !decInReady);
endmodule

// File: rtl/zero_word_codec.sv
module zero_word_codec
  import zrc_pkg::*;
#(
  parameter int W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [W-1:0]     inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic             flush,
  output logic [W-1:0]     encData,
  output logic             encValid,
  input  logic             encReady,
  input  logic [W-1:0]     decIn,
  input  logic             decInValid,
  output logic             decInReady,
  input  logic             decStart,
  input  logic [CNT_W-1:0] decCount,
  output logic [W-1:0]     decOut,
  output logic             decOutValid,
  input  logic             decOutReady
);
  localparam int FILL_W = $clog2(2 * W + 1);

  zrc_strobe_t       stb;
  logic [FILL_W-1:0] encFill, decFill;
  logic              decTokValid, decNeedHold, decNeedFire;

  zrc_ctrl #(.W(W), .CNT_W(CNT_W), .FILL_W(FILL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .encReady(encReady), .flush(flush),
    .encFill(encFill), .decInValid(decInValid), .decOutReady(decOutReady),
    .decStart(decStart), .decCount(decCount), .decTokValid(decTokValid),
    .decNeedHold(decNeedHold), .decNeedFire(decNeedFire), .stb(stb),
    .inReady(inReady), .encValid(encValid), .decInReady(decInReady),
    .decOutValid(decOutValid)
  );

  zrc_dpath #(.W(W), .FILL_W(FILL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .decIn(decIn),
    .encFill(encFill), .encWord(encData), .decFill(decFill),
    .decTokValid(decTokValid), .decNeedHold(decNeedHold),
    .decNeedFire(decNeedFire), .decWord(decOut)
  );

  // R10
  dec_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    decOutValid && !decOutReady |=> $stable(decOut));
  // R6
  enc_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValid && !encReady |=> $stable(encData));
endmodule

// File: tb/tb_zero_word_codec.sv
module tb_zero_word_codec;
  localparam int W = 32;
  localparam int CW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic [W-1:0] inData = '0, decIn = '0;
  logic inValid = 1'b0, flush = 1'b0, encReady = 1'b0;
  logic decInValid = 1'b0, decStart = 1'b0, decOutReady = 1'b0;
  logic [CW-1:0] decCount = '0;
  logic inReady, encValid, decInReady, decOutValid;
  logic [W-1:0] encData, decOut;

  always #4 clk = ~clk;

  zero_word_codec #(.W(W), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .flush(flush), .encData(encData), .encValid(encValid), .encReady(encReady),
    .decIn(decIn), .decInValid(decInValid), .decInReady(decInReady),
    .decStart(decStart), .decCount(decCount), .decOut(decOut),
    .decOutValid(decOutValid), .decOutReady(decOutReady)
  );

  int nChecks = 0, nFails = 0;
  logic [W-1:0] srcQ[$], encExpQ[$], encGot[$], decExpQ[$];
  int stalls, consumed;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit rdy(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) != 1;
      default: return ((cyc * 5) % 7) < 3;
    endcase
  endfunction

  // packing model built from R2/R3/R4/R5
  task automatic buildExp();
    bit bq[$];
    encExpQ.delete();
    foreach (srcQ[i]) begin
      if (srcQ[i] == '0) bq.push_back(1'b0);
      else begin
        bq.push_back(1'b1);
        for (int b = W - 1; b >= 0; b--) bq.push_back(srcQ[i][b]);
      end
    end
    while (bq.size() % W != 0) bq.push_back(1'b0);
    for (int k = 0; k < bq.size(); k += W) begin
      logic [W-1:0] w;
      for (int b = 0; b < W; b++) w[W-1-b] = bq[k+b];
      encExpQ.push_back(w);
    end
  endtask

  task automatic runEncode(input int mode);
    int n;
    buildExp();
    n = encExpQ.size();
    encGot.delete();
    stalls = 0;
    fork
      begin : driver
        foreach (srcQ[i]) begin
          @(negedge clk); inValid = 1'b1; inData = srcQ[i]; #1;
          while (!inReady) begin stalls++; @(negedge clk); #1; end
        end
        @(negedge clk); inValid = 1'b0; flush = 1'b1;
        @(negedge clk); flush = 1'b0;
      end
      begin : monitor
        int cyc = 0;
        while (encGot.size() < n && cyc < 5000) begin
          @(negedge clk); encReady = rdy(mode, cyc); #1;
          if (encValid && encReady) begin
            logic [W-1:0] e = encExpQ.pop_front();
            check(encData == e, "R4 packed word", encData, e);
            encGot.push_back(encData);
          end
          cyc++;
        end
        check(encGot.size() == n, "R6 word count", encGot.size(), n);
      end
    join
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); encReady = 1'b1; #1;
      if (encValid) check(1'b0, "R5 no extra word after flush", encData, '0);
    end
    check(inReady == 1'b1, "R5 inReady back after flush", inReady, 1);
  endtask

  task automatic runDecode(input int mode, input bit midStart);
    int cnt = srcQ.size();
    int got = 0;
    decExpQ = srcQ;
    consumed = 0;
    @(negedge clk); decStart = 1'b1; decCount = CW'(cnt);
    @(negedge clk); decStart = 1'b0;
    fork
      begin : driver
        foreach (encGot[i]) begin
          int guard = 0;
          @(negedge clk); decInValid = 1'b1; decIn = encGot[i]; #1;
          while (!decInReady && guard < 3000) begin guard++; @(negedge clk); #1; end
          if (decInReady) consumed++;
        end
        @(negedge clk); decInValid = 1'b0;
      end
      begin : monitor
        int cyc = 0;
        while (got < cnt && cyc < 5000) begin
          @(negedge clk);
          decOutReady = rdy(mode, cyc);
          if (midStart) begin
            decStart = (cyc == 5); decCount = 3;
          end
          #1;
          if (decOutValid && decOutReady) begin
            logic [W-1:0] e = decExpQ.pop_front();
            check(decOut == e, "R7 decoded word", decOut, e);
            got++;
          end
          cyc++;
        end
        decStart = 1'b0;
        check(got == cnt, midStart ? "R9 count unchanged by restart" : "R8 word count", got, cnt);
      end
    join
    check(consumed == encGot.size(), "R8 input words consumed", consumed, encGot.size());
    @(negedge clk); decInValid = 1'b1; decIn = '1; decOutReady = 1'b1;
    for (int c = 0; c < 6; c++) begin
      #1;
      if (decOutValid || decInReady) check(1'b0, "R8 idle after count", {decOutValid, decInReady}, 0);
      @(negedge clk);
    end
    decInValid = 1'b0;
    check(!decOutValid && !decInReady, "R8 idle after count", {decOutValid, decInReady}, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(!encValid, "R1 encValid reset", encValid, 0);
    check(inReady, "R1 inReady reset", inReady, 1);
    check(!decOutValid, "R1 decOutValid reset", decOutValid, 0);
    check(!decInReady, "R1 decInReady reset", decInReady, 0);

    // R3 single non-zero word
    srcQ = '{32'hA5A5A5A5};
    runEncode(0);
    check(encGot.size() == 2 && encGot[0] == 32'hD2D2D2D2, "R3 first word", encGot[0], 32'hD2D2D2D2);
    check(encGot.size() == 2 && encGot[1] == 32'h80000000, "R3 spill word", encGot[1], 32'h80000000);
    runDecode(0, 1'b0);

    // R2 zero tokens are one bit
    srcQ = '{32'h0, 32'h0, 32'hFFFFFFFF};
    runEncode(0);
    check(encGot.size() == 2 && encGot[0] == 32'h3FFFFFFF, "R2 first word", encGot[0], 32'h3FFFFFFF);
    check(encGot.size() == 2 && encGot[1] == 32'hE0000000, "R2 second word", encGot[1], 32'hE0000000);
    runDecode(0, 1'b0);

    // R5 flush on empty encoder
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int c = 0; c < 6; c++) begin
      #1; if (encValid) check(1'b0, "R5 empty flush emits nothing", encData, 0);
      @(negedge clk);
    end
    #1; check(inReady, "R5 inReady after empty flush", inReady, 1);

    // R11 all-zero stream at full rate
    srcQ.delete();
    for (int i = 0; i < 70; i++) srcQ.push_back('0);
    runEncode(0);
    check(stalls == 0, "R11 zero stream stalls", stalls, 0);
    runDecode(1, 1'b0);

    // R4/R7 mixed stream, backpressure both sides (R6, R10)
    srcQ.delete();
    for (int i = 0; i < 60; i++)
      srcQ.push_back((i % 4 == 0 || i % 7 == 3) ? 32'h0 : ((i * 32'h9E3779B1) ^ 32'h5A00F00D) | 32'h1);
    runEncode(1);
    runDecode(2, 1'b0);

    // R6 dense non-zero stream under heavy stall, R9 restart ignored
    srcQ.delete();
    for (int i = 0; i < 25; i++) srcQ.push_back(32'h80000001 + 32'(i * 32'h01010101));
    runEncode(2);
    runDecode(1, 1'b1);

    summary();
    $finish;
  end
endmodule